// File: doc/BRIEF.md
# Receive Overrun Classifier

This block watches one receive frame at a time and decides what happens to it when the receive FIFO or the receive DMA runs out of room. At the first cycle of a frame it samples both resource indications. If either is missing at that point, the whole frame is a start-of-frame overrun: it is dropped, whatever the enables say. If both are present at the start but one goes away later in the same frame, the frame is a middle-of-frame overrun. The address-match result and the two enables then decide whether the frame is dropped or kept up to the point of the overrun. A kept frame goes to its normal channel with a truncate mark and the overrun descriptor flag.

The outcome is held on the outputs until the next frame starts. Each overrun also gives a one-cycle pulse. Three saturating statistics counters are built from these pulses: start-of-frame, middle-of-frame and DMA-sourced overruns. A small register port reads the counters, and a write to a counter clears it.

Top module: `rx_overrun_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: `dest` (2'b00 = drop), `truncate`, `flag_overrun`, `flag_nomatch`, the three pulse outputs and all three counters.
- R2: The block samples `addr_match`, `en_promisc` and `en_errframe` on the `frame_start` cycle. If the frame has no overrun, `dest` is one of three codes. It is 2'b10 (address-match channel) on a match. With no match and promiscuous on, it is 2'b01 (promiscuous channel) and `flag_nomatch` is 1. Otherwise it is 2'b00. `truncate`, `flag_overrun` and all pulses stay 0.
- R3: If `fifo_ok` or `dma_ok` is low on the `frame_start` cycle, `dest` is drop and all three flags are 0, for every enable setting. `inc_sof` pulses once.
- R4: A middle-of-frame overrun (first low resource after the start cycle, up to and including the `frame_end` cycle) drops the frame in three cases: no match with promiscuous off; no match with promiscuous on and error-frame acceptance off; a match with error-frame acceptance off. In every case `inc_mof` still pulses once and all flags are 0.
- R5: A middle-of-frame overrun with no match, promiscuous on and error-frame acceptance on gives `dest`=promiscuous. `truncate`, `flag_overrun` and `flag_nomatch` are all 1.
- R6: A middle-of-frame overrun with a match and error-frame acceptance on gives `dest`=address-match and sets `truncate` and `flag_overrun`. `flag_nomatch` stays 0.
- R7: `inc_dma` pulses together with `inc_sof` or `inc_mof` when `dma_ok` was low in the overrun cycle. If only `fifo_ok` was low, `inc_dma` does not pulse.
- R8: Only the first overrun cycle of a frame counts and decides the treatment. Later low-resource cycles in the same frame, and cycles between frames, give no pulse and do not change the outputs.
- R9: Each counter is `CNT_W` bits wide (default 32). It adds one per pulse and holds at all ones.
- R10: `csr_rdata` shows the counter selected by `csr_addr`: 0 is start-of-frame, 1 is middle-of-frame, 2 is DMA, and 3 reads 0. A cycle with `csr_wr` high clears only the addressed counter.
- R11: The outputs are registered. The decision for a frame start or an overrun appears in the cycle after that event. A counter shows its increment in the cycle after its pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | First cycle of a received frame |
| frame_end | input | 1 | Last cycle of the frame (may equal the first) |
| fifo_ok | input | 1 | Receive FIFO has room this cycle |
| dma_ok | input | 1 | Receive DMA has room this cycle |
| addr_match | input | 1 | Destination address matched, valid at frame start |
| en_promisc | input | 1 | Accept frames without an address match |
| en_errframe | input | 1 | Accept frames that carry errors, overruns included |
| dest | output | 2 | 00 drop, 01 promiscuous channel, 10 address-match channel |
| truncate | output | 1 | Frame is delivered only up to the overrun point |
| flag_overrun | output | 1 | Overrun flag for the start-of-packet descriptor |
| flag_nomatch | output | 1 | No-match flag for the start-of-packet descriptor |
| inc_sof | output | 1 | One-cycle start-of-frame overrun pulse |
| inc_mof | output | 1 | One-cycle middle-of-frame overrun pulse |
| inc_dma | output | 1 | One-cycle DMA-sourced overrun pulse |
| csr_wr | input | 1 | Write strobe: clears the addressed counter |
| csr_addr | input | 2 | Counter select |
| csr_rdata | output | CNT_W | Selected counter value |

## Verification
Directed frames cover all eight settings of match, promiscuous and error-frame acceptance, each with a middle-of-frame overrun. These frames tell the three drop rows apart from the two keep rows, and they tell the promiscuous keep (which carries the no-match flag) from the address-match keep. Start-of-frame overruns with the enables all on are run from the FIFO, from the DMA and from both. These separate the unconditional drop from the middle-of-frame outcome and separate the DMA pulse from the FIFO-only case. Frames with several low-resource cycles, and low resources between frames, show that only the first overrun counts. Random frames with a fixed seed then mix lengths, overrun positions and sources. A narrow counter width lets the bench reach saturation, and it also checks that a clear reaches only the addressed counter.

// File: rtl/rx_ovr_pkg.sv
// Package: shared destination encoding for the receive overrun classifier.
// Assumes: the codes are decoded by the neighbouring receive datapath.
package rx_ovr_pkg;
    typedef enum logic [1:0] {
        DEST_DROP    = 2'b00,
        DEST_PROMISC = 2'b01,
        DEST_MATCH   = 2'b10
    } dest_e;

    localparam int NUM_CNT = 3;
    localparam int IDX_SOF = 0;
    localparam int IDX_MOF = 1;
    localparam int IDX_DMA = 2;
endpackage

// File: rtl/rx_ovr_policy.sv
// Module: rx_ovr_policy
// Pure combinational treatment table. From the match result and the two
// enables it gives the normal destination of a frame and whether a frame
// that overruns part-way may still be kept.
// Assumes: inputs are valid on the frame-start cycle; the caller latches.
module rx_ovr_policy
    import rx_ovr_pkg::*;
(
    input  logic  match_i,
    input  logic  promisc_i,
    input  logic  errframe_i,
    output dest_e normal_dest_o,
    output logic  normal_nomatch_o,
    output logic  mof_keep_o
);
    // Normal routing and the keep rule for a mid-frame overrun.
    always_comb begin
        if (match_i) begin
            normal_dest_o    = DEST_MATCH;
            normal_nomatch_o = 1'b0;
        end else if (promisc_i) begin
            normal_dest_o    = DEST_PROMISC;
            normal_nomatch_o = 1'b1;
        end else begin
            normal_dest_o    = DEST_DROP;
            normal_nomatch_o = 1'b0;
        end
        mof_keep_o = errframe_i & (match_i | promisc_i);
    end
endmodule

// File: rtl/rx_ovr_classifier.sv
// Module: rx_ovr_classifier
// Per-frame overrun tracker. A resource shortfall on the start cycle is a
// start-of-frame overrun. The first shortfall after the start is a
// middle-of-frame overrun. The decision is registered and held until the
// next frame starts, and each counted overrun gives one-cycle pulses.
// Assumes: frame_start marks the first cycle of a frame and frame_end the
// last cycle; both may be high together for a one-cycle frame.
module rx_ovr_classifier
    import rx_ovr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frame_start_i,
    input  logic  frame_end_i,
    input  logic  fifo_ok_i,
    input  logic  dma_ok_i,
    input  dest_e normal_dest_i,
    input  logic  normal_nomatch_i,
    input  logic  mof_keep_i,
    output dest_e dest_o,
    output logic  truncate_o,
    output logic  flag_overrun_o,
    output logic  flag_nomatch_o,
    output logic  inc_sof_o,
    output logic  inc_mof_o,
    output logic  inc_dma_o
);
    logic in_frame_q;
    logic ovr_seen_q;
    logic keep_q;
    logic short_w;

    // A cycle lacks resources if either the FIFO or the DMA has no room.
    assign short_w = ~fifo_ok_i | ~dma_ok_i;

    // Frame tracking, treatment decision and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q     <= 1'b0;
            ovr_seen_q     <= 1'b0;
            keep_q         <= 1'b0;
            dest_o         <= DEST_DROP;
            truncate_o     <= 1'b0;
            flag_overrun_o <= 1'b0;
            flag_nomatch_o <= 1'b0;
            inc_sof_o      <= 1'b0;
            inc_mof_o      <= 1'b0;
            inc_dma_o      <= 1'b0;
        end else begin
            inc_sof_o <= 1'b0;
            inc_mof_o <= 1'b0;
            inc_dma_o <= 1'b0;
            if (frame_start_i) begin
                in_frame_q     <= ~frame_end_i;
                ovr_seen_q     <= short_w;
                keep_q         <= mof_keep_i;
                truncate_o     <= 1'b0;
                flag_overrun_o <= 1'b0;
                if (short_w) begin
                    dest_o         <= DEST_DROP;
                    flag_nomatch_o <= 1'b0;
                    inc_sof_o      <= 1'b1;
                    inc_dma_o      <= ~dma_ok_i;
                end else begin
                    dest_o         <= normal_dest_i;
                    flag_nomatch_o <= normal_nomatch_i;
                end
            end else if (in_frame_q) begin
                if (frame_end_i) begin
                    in_frame_q <= 1'b0;
                end
                if (short_w && !ovr_seen_q) begin
                    ovr_seen_q <= 1'b1;
                    inc_mof_o  <= 1'b1;
                    inc_dma_o  <= ~dma_ok_i;
                    if (keep_q) begin
                        truncate_o     <= 1'b1;
                        flag_overrun_o <= 1'b1;
                    end else begin
                        dest_o         <= DEST_DROP;
                        flag_nomatch_o <= 1'b0;
                    end
                end
            end
        end
    end

    // R3: a start-of-frame overrun always leaves the frame dropped and unflagged.
    p_sof_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inc_sof_o |-> (dest_o == DEST_DROP && !truncate_o && !flag_overrun_o && !flag_nomatch_o));

    // R7: a DMA pulse never comes without its start or middle pulse.
    p_dma_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inc_dma_o |-> (inc_sof_o || inc_mof_o));

    // R8: one overrun kind per event, never both.
    p_one_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_sof_o && inc_mof_o));

    // R8: a middle-of-frame pulse is never repeated in the next cycle.
    p_mof_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inc_mof_o |=> !inc_mof_o);

    // R5, R6: a truncated frame is always flagged and delivered somewhere.
    p_trunc_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        truncate_o |-> (flag_overrun_o && dest_o != DEST_DROP));

    // R8: outside a frame, a missing resource does not change the outputs.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_frame_q && !frame_start_i) |=> ($stable(dest_o) && !inc_mof_o && !inc_sof_o));
endmodule

// File: rtl/rx_ovr_sat_counter.sv
// Module: rx_ovr_sat_counter
// One statistics counter. It adds one per increment pulse, holds at all
// ones, and clears on a write strobe.
// Assumes: a clear and an increment in the same cycle resolve to zero.
module rx_ovr_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] MAX_VAL = '1;

    // Saturating count with priority to the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i && cnt_o != MAX_VAL) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    // R9: a full counter never wraps.
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == MAX_VAL && !clr_i) |=> cnt_o == MAX_VAL);

    // R10: after a clear the counter reads zero.
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_o == '0);

    // R9: without a pulse or a clear, the value holds.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rx_overrun_ctrl.sv
// Module: rx_overrun_ctrl
// Top of the receive overrun classifier. It joins the treatment table, the
// per-frame tracker and a bank of saturating statistics counters, which
// are read and cleared through a small register port.
// Assumes: the register read is combinational on csr_addr.
module rx_overrun_ctrl
    import rx_ovr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             fifo_ok,
    input  logic             dma_ok,
    input  logic             addr_match,
    input  logic             en_promisc,
    input  logic             en_errframe,
    output logic [1:0]       dest,
    output logic             truncate,
    output logic             flag_overrun,
    output logic             flag_nomatch,
    output logic             inc_sof,
    output logic             inc_mof,
    output logic             inc_dma,
    input  logic             csr_wr,
    input  logic [1:0]       csr_addr,
    output logic [CNT_W-1:0] csr_rdata
);
    dest_e             normal_dest;
    logic              normal_nomatch;
    logic              mof_keep;
    dest_e             dest_q;
    logic [NUM_CNT-1:0] inc_vec;
    logic [CNT_W-1:0]  cnt_q [NUM_CNT];

    rx_ovr_policy u_policy (
        .match_i          (addr_match),
        .promisc_i        (en_promisc),
        .errframe_i       (en_errframe),
        .normal_dest_o    (normal_dest),
        .normal_nomatch_o (normal_nomatch),
        .mof_keep_o       (mof_keep)
    );

    rx_ovr_classifier u_classifier (
        .clk              (clk),
        .rst_n            (rst_n),
        .frame_start_i    (frame_start),
        .frame_end_i      (frame_end),
        .fifo_ok_i        (fifo_ok),
        .dma_ok_i         (dma_ok),
        .normal_dest_i    (normal_dest),
        .normal_nomatch_i (normal_nomatch),
        .mof_keep_i       (mof_keep),
        .dest_o           (dest_q),
        .truncate_o       (truncate),
        .flag_overrun_o   (flag_overrun),
        .flag_nomatch_o   (flag_nomatch),
        .inc_sof_o        (inc_sof),
        .inc_mof_o        (inc_mof),
        .inc_dma_o        (inc_dma)
    );

    assign dest = dest_q;

    // Gather the pulses in counter-index order.
    always_comb begin
        inc_vec          = '0;
        inc_vec[IDX_SOF] = inc_sof;
        inc_vec[IDX_MOF] = inc_mof;
        inc_vec[IDX_DMA] = inc_dma;
    end

    // One saturating counter per statistic, each cleared by its own address.
    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        rx_ovr_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (inc_vec[gi]),
            .clr_i (csr_wr && (csr_addr == gi[1:0])),
            .cnt_o (cnt_q[gi])
        );
    end

    // Read mux; the unused address reads zero.
    always_comb begin
        case (csr_addr)
            2'd0:    csr_rdata = cnt_q[IDX_SOF];
            2'd1:    csr_rdata = cnt_q[IDX_MOF];
            2'd2:    csr_rdata = cnt_q[IDX_DMA];
            default: csr_rdata = '0;
        endcase
    end
endmodule

// File: tb/rx_overrun_ctrl_bench.sv
`timescale 1ns/1ps
module rx_overrun_ctrl_bench;
    localparam int CW = 4;
    localparam logic [CW-1:0] CMAX = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 0, frame_end = 0, fifo_ok = 1, dma_ok = 1;
    logic addr_match = 0, en_promisc = 0, en_errframe = 0;
    logic [1:0] dest;
    logic truncate, flag_overrun, flag_nomatch, inc_sof, inc_mof, inc_dma;
    logic csr_wr = 0;
    logic [1:0] csr_addr = 0;
    logic [CW-1:0] csr_rdata;

    int checks = 0;
    int errors = 0;
    int exp_cnt [3] = '{0, 0, 0};
    bit done = 0;

    always #2.5 clk = ~clk;

    rx_overrun_ctrl #(.CNT_W(CW)) u_rx_overrun_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .fifo_ok(fifo_ok), .dma_ok(dma_ok), .addr_match(addr_match),
        .en_promisc(en_promisc), .en_errframe(en_errframe), .dest(dest),
        .truncate(truncate), .flag_overrun(flag_overrun), .flag_nomatch(flag_nomatch),
        .inc_sof(inc_sof), .inc_mof(inc_mof), .inc_dma(inc_dma),
        .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_rdata(csr_rdata));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected destination from the requirement table.
    function automatic int exp_dest(input bit ev, input bit sof, input bit m, input bit p, input bit e);
        int nd;
        nd = m ? 2 : (p ? 1 : 0);
        if (!ev) return nd;
        if (sof) return 0;
        return (e && (m || p)) ? nd : 0;
    endfunction

    function automatic bit exp_keep(input bit ev, input bit sof, input bit m, input bit p, input bit e);
        return ev && !sof && e && (m || p);
    endfunction

    task automatic check_counters(input string tag);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            csr_addr = k[1:0];
            #0.5;
            chk(tag, int'(csr_rdata), (k < 3) ? exp_cnt[k] : 0);
        end
    endtask

    task automatic clear_cnt(input int k);
        @(negedge clk);
        csr_wr = 1; csr_addr = k[1:0];
        @(negedge clk);
        csr_wr = 0;
        if (k < 3) exp_cnt[k] = 0;
    endtask

    function automatic int sat_add(input int v);
        return (v >= int'(CMAX)) ? int'(CMAX) : v + 1;
    endfunction

    // Run one frame; bit i of fm/dm is the FIFO/DMA availability in cycle i.
    task automatic run_frame(input int len, input bit m, input bit p, input bit e,
                             input logic [7:0] fm, input logic [7:0] dm, input string tag);
        bit ev = 0, sof = 0, evdma = 0;
        int evi = 0, ns = 0, nm = 0, nd = 0, ed;
        for (int i = 0; i < len; i++) begin
            if (!ev && !(fm[i] && dm[i])) begin
                ev = 1; evi = i; sof = (i == 0); evdma = !dm[i];
            end
        end
        ed = exp_dest(ev, sof, m, p, e);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            frame_start = (i == 0); frame_end = (i == len - 1);
            fifo_ok = fm[i]; dma_ok = dm[i];
            addr_match = (i == 0) ? m : $urandom_range(1);
            en_promisc = p; en_errframe = e;
            @(posedge clk); #1;
            ns += int'(inc_sof); nm += int'(inc_mof); nd += int'(inc_dma);
            if (ev && i == evi) chk({tag, " R11 dest right after event"}, int'(dest), ed);
        end
        @(negedge clk);
        frame_start = 0; frame_end = 0;
        fifo_ok = $urandom_range(1); dma_ok = $urandom_range(1);
        @(posedge clk); #1;
        chk({tag, " R8 no pulse between frames"}, int'(inc_sof | inc_mof | inc_dma), 0);
        chk({tag, " R2/R4/R5/R6 dest"}, int'(dest), ed);
        chk({tag, " R5/R6 truncate"}, int'(truncate), int'(exp_keep(ev, sof, m, p, e)));
        chk({tag, " R5/R6 overrun flag"}, int'(flag_overrun), int'(exp_keep(ev, sof, m, p, e)));
        chk({tag, " R2/R5 nomatch flag"}, int'(flag_nomatch), int'(ed == 1));
        chk({tag, " R3 sof pulses"}, ns, int'(ev && sof));
        chk({tag, " R8 mof pulses"}, nm, int'(ev && !sof));
        chk({tag, " R7 dma pulses"}, nd, int'(ev && evdma));
        @(negedge clk);
        fifo_ok = 1; dma_ok = 1;
        if (ev && sof) exp_cnt[0] = sat_add(exp_cnt[0]);
        if (ev && !sof) exp_cnt[1] = sat_add(exp_cnt[1]);
        if (ev && evdma) exp_cnt[2] = sat_add(exp_cnt[2]);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        // R1: reset state
        chk("R1 dest", int'(dest), 0);
        chk("R1 flags", int'({truncate, flag_overrun, flag_nomatch}), 0);
        chk("R1 pulses", int'({inc_sof, inc_mof, inc_dma}), 0);
        check_counters("R1 counters");

        // R2: normal frames for each match/promiscuous pair
        run_frame(4, 1, 0, 0, 8'hFF, 8'hFF, "R2 match");
        run_frame(4, 0, 1, 0, 8'hFF, 8'hFF, "R2 promisc");
        run_frame(4, 0, 0, 1, 8'hFF, 8'hFF, "R2 none");
        run_frame(1, 1, 1, 1, 8'hFF, 8'hFF, "R2 one-cycle");

        // R3 and R7: start-of-frame overrun from each source, enables all on
        run_frame(3, 1, 1, 1, 8'hFE, 8'hFF, "R3 fifo sof");
        run_frame(3, 0, 1, 1, 8'hFF, 8'hFE, "R3 R7 dma sof");
        run_frame(3, 1, 1, 1, 8'hFE, 8'hFE, "R3 R7 both sof");
        check_counters("R10 read after sof");

        // R4, R5, R6: all eight enable settings with a mid-frame FIFO overrun
        for (int c = 0; c < 8; c++)
            run_frame(5, c[2], c[1], c[0], 8'hFB, 8'hFF, "R4/R5/R6 mof table");
        // R7: DMA mid-frame overrun; R8: repeated shortfall in the same frame
        run_frame(6, 1, 0, 1, 8'hFF, 8'hF9, "R7 dma mof");
        run_frame(6, 0, 1, 1, 8'hD5, 8'hEF, "R8 repeated shortfall");
        run_frame(3, 0, 1, 1, 8'hFB, 8'hFF, "R4 overrun on last cycle");
        check_counters("R10 read after mof");

        // R10: clearing one counter leaves the others
        clear_cnt(1);
        check_counters("R10 clear mof only");
        clear_cnt(3);
        check_counters("R10 addr 3 write");

        // R9: saturation of the start-of-frame counter
        for (int n = 0; n < 18; n++)
            run_frame(1, 0, 0, 0, 8'h00, 8'hFF, "R9 fill");
        check_counters("R9 saturated");
        for (int k = 0; k < 3; k++) clear_cnt(k);
        check_counters("R10 all cleared");

        // Random frames mixing lengths, overrun positions and sources
        for (int n = 0; n < 60; n++) begin
            int len;
            logic [7:0] fm, dm;
            len = $urandom_range(8, 1);
            fm = 8'($urandom) | 8'($urandom) | 8'($urandom);
            dm = 8'($urandom) | 8'($urandom) | 8'($urandom);
            run_frame(len, $urandom_range(1), $urandom_range(1), $urandom_range(1), fm, dm, "rand");
            if (n % 6 == 5) begin
                check_counters("R9/R10 rand counters");
                for (int k = 0; k < 3; k++) clear_cnt(k);
            end
        end
        done = 1;
    end

    initial begin
        for (int t = 0; t < 100000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule